// File: doc/BRIEF.md
# USB Host Periodic-First Transaction Scheduler

This block sits inside a USB host controller and decides, frame by frame, which queued request goes next. Two request queues feed it: one holds periodic work and the other holds non-periodic work. Each queue presents its oldest entry as a head. An entry is either a transaction request or a channel-disable request. A transaction request enters its queue on its own once software has written a complete packet into the transmit FIFO, so the scheduler only sees heads that are already valid.

After every start-of-frame pulse the scheduler works on the periodic queue first. It compares each transaction's bus-time estimate with the frame time still left, which arrives as a down-counter value. A channel-disable entry is acted on at once, with no time check. A transaction that fits is popped and offered to the serial interface engine over a valid/ready port. The scheduler then holds until the engine reports completion with a done pulse. It moves to the non-periodic queue when the periodic queue is empty or when a periodic transaction does not fit. It stops completely when a non-periodic transaction does not fit, and stays stopped until the next frame starts.

Top module: `usb_req_sched`

## Requirements
- R1: From reset until the first start-of-frame pulse the scheduler is halted. In that time no pop, no disable strobe and no transaction offer is produced, even when queue heads are valid.
- R2: In a cycle where `sof_i` is high, no entry is popped. From the next cycle the periodic queue is served first, and this also holds when the scheduler was halted.
- R3: While the periodic queue is being served, `np_pop_o` stays low. Only one pop strobe is high in any cycle.
- R4: When a served head is a disable entry (`is_dis` = 1), that queue's pop strobe and `dis_valid_o` are high in the same cycle, and `dis_ch_o` equals the head's channel. The remaining frame time plays no part, and no transaction is offered.
- R5: A transaction head whose bus time is less than or equal to `frame_left_i` is popped in the cycle it is examined. In the next cycle `xact_valid_o` rises, carrying that channel and bus time, with `xact_periodic_o` set to 1 for the periodic queue and 0 for the non-periodic queue.
- R6: If the periodic queue is empty, or its head transaction needs more time than remains, nothing is popped in that cycle and the non-periodic queue is served from the next cycle. The periodic queue is not served again before the next start-of-frame.
- R7: If a non-periodic head transaction needs more time than remains, the scheduler halts. It pops nothing, even if more time is reported later, until the next start-of-frame.
- R8: While `xact_valid_o` is high and `xact_ready_i` is low, the offer and its channel, time and queue fields stay unchanged. `xact_valid_o` is low in the cycle after the handshake.
- R9: From the pop of a transaction until the cycle after a `xact_done_i` pulse that follows the handshake, no entry is popped and no disable strobe is produced.
- R10: While the non-periodic queue is served and is empty, the scheduler waits there. It serves a non-periodic head as soon as one becomes valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sof_i | input | 1 | Start-of-frame pulse |
| frame_left_i | input | 11 | Bus time remaining in the current frame |
| per_valid_i | input | 1 | Periodic queue head valid |
| per_is_dis_i | input | 1 | Periodic head is a disable entry |
| per_ch_i | input | 4 | Periodic head channel |
| per_time_i | input | 11 | Periodic head bus-time estimate |
| np_valid_i | input | 1 | Non-periodic queue head valid |
| np_is_dis_i | input | 1 | Non-periodic head is a disable entry |
| np_ch_i | input | 4 | Non-periodic head channel |
| np_time_i | input | 11 | Non-periodic head bus-time estimate |
| per_pop_o | output | 1 | Pop periodic head |
| np_pop_o | output | 1 | Pop non-periodic head |
| dis_valid_o | output | 1 | Channel-disable strobe |
| dis_ch_o | output | 4 | Channel to disable |
| xact_valid_o | output | 1 | Transaction offered to engine |
| xact_ready_i | input | 1 | Engine accepts offer |
| xact_ch_o | output | 4 | Offered transaction channel |
| xact_time_o | output | 11 | Offered transaction bus time |
| xact_periodic_o | output | 1 | Offered transaction came from periodic queue |
| xact_done_i | input | 1 | Engine finished the outstanding transaction |

## Verification
A phase register stuck on the wrong queue shows one cycle after a start-of-frame pulse. It appears either as a pop on the wrong strobe when both heads are valid, or as a missing pop where one is expected. A lost halt shows as a non-periodic pop appearing in the cycle after a failed fit once more time is reported. A busy state cleared too early shows as a pop while the engine has not yet pulsed done. The tests place both heads in front of the scheduler at the same time and vary the remaining time around each bus-time value, including equality and a one-unit shortfall, so that these faults show up at the pop strobes within one or two cycles.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    PH_HALT = 2'd0,
    PH_PER  = 2'd1,
    PH_NP   = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    IS_IDLE  = 2'd0,
    IS_OFFER = 2'd1,
    IS_WAIT  = 2'd2
  } issue_st_t;
endpackage

// File: rtl/sched_head_sel.sv
module sched_head_sel #(
  parameter int CH_W   = 4,
  parameter int TIME_W = 11
) (
  input  logic              sel_np_i,
  input  logic              per_valid_i,
  input  logic              per_is_dis_i,
  input  logic [CH_W-1:0]   per_ch_i,
  input  logic [TIME_W-1:0] per_time_i,
  input  logic              np_valid_i,
  input  logic              np_is_dis_i,
  input  logic [CH_W-1:0]   np_ch_i,
  input  logic [TIME_W-1:0] np_time_i,
  output logic              hd_valid_o,
  output logic              hd_is_dis_o,
  output logic [CH_W-1:0]   hd_ch_o,
  output logic [TIME_W-1:0] hd_time_o
);
  localparam int HD_W = 2 + CH_W + TIME_W;

  logic [HD_W-1:0] per_hd, np_hd, sel_hd;

  assign per_hd = {per_valid_i, per_is_dis_i, per_ch_i, per_time_i};
  assign np_hd  = {np_valid_i, np_is_dis_i, np_ch_i, np_time_i};

  for (genvar b = 0; b < HD_W; b++) begin : g_mux
    assign sel_hd[b] = sel_np_i ? np_hd[b] : per_hd[b];
  end

  assign {hd_valid_o, hd_is_dis_o, hd_ch_o, hd_time_o} = sel_hd;
endmodule

// File: rtl/sched_fit_chk.sv
module sched_fit_chk #(
  parameter int TIME_W = 11
) (
  input  logic [TIME_W-1:0] need_i,
  input  logic [TIME_W-1:0] left_i,
  output logic              fit_o
);
  // equality fits: the transaction ends exactly at the frame boundary
  assign fit_o = (need_i <= left_i);
endmodule

// File: rtl/sched_issue.sv
module sched_issue
  import sched_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int TIME_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              per_i,
  input  logic              ready_i,
  input  logic              done_i,
  output logic              idle_o,
  output logic              valid_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [TIME_W-1:0] time_o,
  output logic              per_o
);
  issue_st_t         st_q;
  logic [CH_W-1:0]   ch_q;
  logic [TIME_W-1:0] time_q;
  logic              per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= IS_IDLE;
      ch_q   <= '0;
      time_q <= '0;
      per_q  <= 1'b0;
    end else begin
      unique case (st_q)
        IS_IDLE: if (load_i) begin
          st_q   <= IS_OFFER;
          ch_q   <= ch_i;
          time_q <= time_i;
          per_q  <= per_i;
        end
        IS_OFFER: if (ready_i) st_q <= IS_WAIT;
        IS_WAIT:  if (done_i)  st_q <= IS_IDLE;
        default:  st_q <= IS_IDLE;
      endcase
    end
  end

  assign idle_o  = (st_q == IS_IDLE);
  assign valid_o = (st_q == IS_OFFER);
  assign ch_o    = ch_q;
  assign time_o  = time_q;
  assign per_o   = per_q;
endmodule

// File: rtl/usb_req_sched.sv
module usb_req_sched
  import sched_pkg::*;
#(
  parameter int CH_W   = 4,
  parameter int TIME_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sof_i,
  input  logic [TIME_W-1:0] frame_left_i,
  input  logic              per_valid_i,
  input  logic              per_is_dis_i,
  input  logic [CH_W-1:0]   per_ch_i,
  input  logic [TIME_W-1:0] per_time_i,
  input  logic              np_valid_i,
  input  logic              np_is_dis_i,
  input  logic [CH_W-1:0]   np_ch_i,
  input  logic [TIME_W-1:0] np_time_i,
  output logic              per_pop_o,
  output logic              np_pop_o,
  output logic              dis_valid_o,
  output logic [CH_W-1:0]   dis_ch_o,
  output logic              xact_valid_o,
  input  logic              xact_ready_i,
  output logic [CH_W-1:0]   xact_ch_o,
  output logic [TIME_W-1:0] xact_time_o,
  output logic              xact_periodic_o,
  input  logic              xact_done_i
);
  phase_t            phase_q, phase_d;
  logic              sel_np;
  logic              hd_valid, hd_is_dis;
  logic [CH_W-1:0]   hd_ch;
  logic [TIME_W-1:0] hd_time;
  logic              fit, issue_idle, decide, take, load;

  assign sel_np = (phase_q == PH_NP);

  sched_head_sel #(.CH_W(CH_W), .TIME_W(TIME_W)) u_head_sel (
    .sel_np_i    (sel_np),
    .per_valid_i (per_valid_i),
    .per_is_dis_i(per_is_dis_i),
    .per_ch_i    (per_ch_i),
    .per_time_i  (per_time_i),
    .np_valid_i  (np_valid_i),
    .np_is_dis_i (np_is_dis_i),
    .np_ch_i     (np_ch_i),
    .np_time_i   (np_time_i),
    .hd_valid_o  (hd_valid),
    .hd_is_dis_o (hd_is_dis),
    .hd_ch_o     (hd_ch),
    .hd_time_o   (hd_time)
  );

  sched_fit_chk #(.TIME_W(TIME_W)) u_fit (
    .need_i(hd_time),
    .left_i(frame_left_i),
    .fit_o (fit)
  );

  // no decision in the SOF cycle; phase re-arms first
  assign decide = issue_idle && !sof_i && (phase_q != PH_HALT);

  always_comb begin
    take    = 1'b0;
    load    = 1'b0;
    phase_d = phase_q;
    if (sof_i) begin
      phase_d = PH_PER;
    end else if (decide) begin
      if (hd_valid && hd_is_dis) begin
        take = 1'b1;
      end else if (hd_valid && fit) begin
        take = 1'b1;
        load = 1'b1;
      end else if (phase_q == PH_PER) begin
        phase_d = PH_NP;
      end else if (hd_valid) begin
        phase_d = PH_HALT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_HALT;
    else         phase_q <= phase_d;
  end

  assign per_pop_o   = take && !sel_np;
  assign np_pop_o    = take && sel_np;
  assign dis_valid_o = take && hd_is_dis;
  assign dis_ch_o    = hd_ch;

  sched_issue #(.CH_W(CH_W), .TIME_W(TIME_W)) u_issue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .ch_i   (hd_ch),
    .time_i (hd_time),
    .per_i  (!sel_np),
    .ready_i(xact_ready_i),
    .done_i (xact_done_i),
    .idle_o (issue_idle),
    .valid_o(xact_valid_o),
    .ch_o   (xact_ch_o),
    .time_o (xact_time_o),
    .per_o  (xact_periodic_o)
  );
endmodule

// File: rtl/usb_req_sched_checker.sv
module usb_req_sched_checker #(
  parameter int CH_W   = 4,
  parameter int TIME_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sof_i,
  input logic [TIME_W-1:0] frame_left_i,
  input logic [CH_W-1:0]   per_ch_i,
  input logic [TIME_W-1:0] per_time_i,
  input logic              per_pop_o,
  input logic              np_pop_o,
  input logic              dis_valid_o,
  input logic [CH_W-1:0]   dis_ch_o,
  input logic              xact_valid_o,
  input logic              xact_ready_i,
  input logic [CH_W-1:0]   xact_ch_o,
  input logic [TIME_W-1:0] xact_time_o
);
  a_r2_no_pop_on_sof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> !per_pop_o && !np_pop_o);

  a_r3_single_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(per_pop_o && np_pop_o));

  a_r4_dis_with_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dis_valid_o |-> (per_pop_o || np_pop_o));

  a_r4_dis_ch_per: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_valid_o && per_pop_o) |-> dis_ch_o == per_ch_i);

  a_r5_per_fit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_pop_o && !dis_valid_o) |-> per_time_i <= frame_left_i);

  a_r5_offer_after_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xact_valid_o) |-> $past(per_pop_o || np_pop_o));

  a_r8_hold_offer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_valid_o && !xact_ready_i) |=> xact_valid_o && $stable(xact_ch_o) && $stable(xact_time_o));

  a_r8_drop_after_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xact_valid_o && xact_ready_i) |=> !xact_valid_o);

  a_r9_busy_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xact_valid_o |-> !per_pop_o && !np_pop_o && !dis_valid_o);
endmodule

bind usb_req_sched usb_req_sched_checker #(.CH_W(CH_W), .TIME_W(TIME_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sof_i       (sof_i),
  .frame_left_i(frame_left_i),
  .per_ch_i    (per_ch_i),
  .per_time_i  (per_time_i),
  .per_pop_o   (per_pop_o),
  .np_pop_o    (np_pop_o),
  .dis_valid_o (dis_valid_o),
  .dis_ch_o    (dis_ch_o),
  .xact_valid_o(xact_valid_o),
  .xact_ready_i(xact_ready_i),
  .xact_ch_o   (xact_ch_o),
  .xact_time_o (xact_time_o)
);

// File: tb/usb_req_sched_bench.sv
`timescale 1ns/1ps
module usb_req_sched_bench;
  localparam int CH_W = 4;
  localparam int TW   = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sof_i = 1'b0;
  logic [TW-1:0] frame_left_i = '0;
  logic per_valid_i = 0, per_is_dis_i = 0, np_valid_i = 0, np_is_dis_i = 0;
  logic [CH_W-1:0] per_ch_i = '0, np_ch_i = '0;
  logic [TW-1:0] per_time_i = '0, np_time_i = '0;
  logic per_pop_o, np_pop_o, dis_valid_o, xact_valid_o, xact_periodic_o;
  logic [CH_W-1:0] dis_ch_o, xact_ch_o;
  logic [TW-1:0] xact_time_o;
  logic xact_ready_i = 1'b0, xact_done_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  usb_req_sched #(.CH_W(CH_W), .TIME_W(TW)) u_usb_req_sched (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof_i), .frame_left_i(frame_left_i),
    .per_valid_i(per_valid_i), .per_is_dis_i(per_is_dis_i), .per_ch_i(per_ch_i), .per_time_i(per_time_i),
    .np_valid_i(np_valid_i), .np_is_dis_i(np_is_dis_i), .np_ch_i(np_ch_i), .np_time_i(np_time_i),
    .per_pop_o(per_pop_o), .np_pop_o(np_pop_o), .dis_valid_o(dis_valid_o), .dis_ch_o(dis_ch_o),
    .xact_valid_o(xact_valid_o), .xact_ready_i(xact_ready_i), .xact_ch_o(xact_ch_o),
    .xact_time_o(xact_time_o), .xact_periodic_o(xact_periodic_o), .xact_done_i(xact_done_i)
  );

  typedef struct packed {
    logic          is_dis;
    logic [3:0]    ch;
    logic [10:0]   need;
    logic [10:0]   left;
    logic          e_pop;
    logic          e_dis;
    logic          e_issue;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 4'd1,  11'd100,  11'd200,  1'b1, 1'b0, 1'b1},
    '{1'b1, 4'd6,  11'd2047, 11'd0,    1'b1, 1'b1, 1'b0},
    '{1'b0, 4'd2,  11'd300,  11'd300,  1'b1, 1'b0, 1'b1},
    '{1'b0, 4'd3,  11'd301,  11'd300,  1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd15, 11'd0,    11'd0,    1'b1, 1'b0, 1'b1},
    '{1'b1, 4'd0,  11'd5,    11'd2047, 1'b1, 1'b1, 1'b0},
    '{1'b0, 4'd9,  11'd2047, 11'd2046, 1'b0, 1'b0, 1'b0},
    '{1'b0, 4'd12, 11'd2047, 11'd2047, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic nedge();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic sof_pulse();
    nedge(); sof_i = 1'b1;
    nedge(); sof_i = 1'b0;
  endtask

  task automatic set_per(input logic v, input logic d, input logic [3:0] c, input logic [10:0] t);
    per_valid_i = v; per_is_dis_i = d; per_ch_i = c; per_time_i = t;
  endtask

  task automatic set_np(input logic v, input logic d, input logic [3:0] c, input logic [10:0] t);
    np_valid_i = v; np_is_dis_i = d; np_ch_i = c; np_time_i = t;
  endtask

  // called right after a negedge while an offer is pending
  task automatic finish_xact();
    xact_ready_i = 1'b1;
    nedge(); xact_ready_i = 1'b0; xact_done_i = 1'b1;
    nedge(); xact_done_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    // R1: reset and halted before first SOF, with heads valid
    set_per(1, 0, 4'd1, 11'd5);
    set_np(1, 0, 4'd2, 11'd5);
    frame_left_i = 11'd100;
    repeat (2) nedge();
    rst_ni = 1'b1;
    repeat (3) begin
      nedge(); settle();
      check("R1 per_pop", per_pop_o, 0);
      check("R1 np_pop", np_pop_o, 0);
      check("R1 xact_valid", xact_valid_o, 0);
      check("R1 dis_valid", dis_valid_o, 0);
    end
    set_per(0, 0, 0, 0);
    set_np(0, 0, 0, 0);

    // vector table: periodic phase, non-periodic queue empty
    for (int i = 0; i < 8; i++) begin
      sof_pulse();
      set_per(1, VECS[i].is_dis, VECS[i].ch, VECS[i].need);
      frame_left_i = VECS[i].left;
      settle();
      check("R5 vec pop", per_pop_o, VECS[i].e_pop);
      check("R4 vec dis", dis_valid_o, VECS[i].e_dis);
      if (VECS[i].e_dis) check("R4 vec dis_ch", dis_ch_o, VECS[i].ch);
      check("R3 vec np_pop", np_pop_o, 0);
      nedge();
      set_per(0, 0, 0, 0);
      settle();
      check("R5 vec offer", xact_valid_o, VECS[i].e_issue);
      if (VECS[i].e_issue) begin
        check("R5 vec ch", xact_ch_o, VECS[i].ch);
        check("R5 vec time", xact_time_o, VECS[i].need);
        check("R5 vec periodic", xact_periodic_o, 1);
        finish_xact();
      end
    end

    // R2: SOF cycle takes no decision, next cycle serves periodic
    nedge();
    set_per(1, 1, 4'd5, 11'd0);
    sof_i = 1'b1;
    settle();
    check("R2 sof cycle pop", per_pop_o, 0);
    nedge(); sof_i = 1'b0; settle();
    check("R2 pop after sof", per_pop_o, 1);
    check("R4 dis ch 5", dis_ch_o, 5);
    nedge(); set_per(0, 0, 0, 0);

    // R3/R9/R6/R10: both heads valid, periodic first, then non-periodic
    sof_pulse();
    frame_left_i = 11'd100;
    set_per(1, 0, 4'd1, 11'd10);
    set_np(1, 0, 4'd2, 11'd5);
    settle();
    check("R3 per first", per_pop_o, 1);
    check("R3 np held", np_pop_o, 0);
    nedge(); set_per(0, 0, 0, 0); settle();
    check("R5 per offer", xact_valid_o, 1);
    check("R9 no np pop busy", np_pop_o, 0);
    xact_ready_i = 1'b1;
    nedge(); xact_ready_i = 1'b0; settle();
    check("R8 drop after hs", xact_valid_o, 0);
    check("R9 no pop before done", np_pop_o, 0);
    nedge(); xact_done_i = 1'b1; settle();
    check("R9 no pop in done cycle", np_pop_o, 0);
    nedge(); xact_done_i = 1'b0; settle();
    check("R6 empty per no pop yet", np_pop_o, 0);
    nedge(); settle();
    check("R6 np served", np_pop_o, 1);
    nedge(); set_np(0, 0, 0, 0); settle();
    check("R5 np offer periodic flag", xact_periodic_o, 0);
    check("R5 np offer ch", xact_ch_o, 2);
    finish_xact();

    // R6 boundary: periodic short by one, non-periodic exactly fits
    sof_pulse();
    frame_left_i = 11'd20;
    set_per(1, 0, 4'd3, 11'd21);
    set_np(1, 0, 4'd4, 11'd20);
    settle();
    check("R6 per miss no pop", per_pop_o, 0);
    check("R6 np not yet", np_pop_o, 0);
    nedge(); settle();
    check("R6 np after miss", np_pop_o, 1);
    check("R6 per still skipped", per_pop_o, 0);
    nedge(); set_np(0, 0, 0, 0); frame_left_i = 11'd100; settle();
    check("R5 equal fit time", xact_time_o, 20);
    finish_xact();
    settle();
    check("R6 per not revisited", per_pop_o, 0);
    nedge(); settle();
    check("R10 np wait empty", np_pop_o, 0);
    set_np(1, 1, 4'd9, 11'd2047);
    settle();
    check("R10 np served when valid", np_pop_o, 1);
    check("R4 np dis", dis_valid_o, 1);
    check("R4 np dis ch", dis_ch_o, 9);

    // R7: non-periodic miss halts until SOF
    nedge(); set_np(1, 0, 4'd7, 11'd500); settle();
    check("R7 np miss no pop", np_pop_o, 0);
    nedge(); frame_left_i = 11'd2047; settle();
    check("R7 halted np", np_pop_o, 0);
    check("R7 halted per", per_pop_o, 0);
    nedge(); settle();
    check("R7 still halted", np_pop_o, 0);
    sof_pulse(); settle();
    check("R7 per after sof", per_pop_o, 1);
    check("R7 np held after sof", np_pop_o, 0);
    nedge(); set_per(0, 0, 0, 0); settle();
    check("R5 per time 21", xact_time_o, 21);
    finish_xact();
    set_np(0, 0, 0, 0);

    // R8: offer held while engine not ready
    sof_pulse();
    frame_left_i = 11'd50;
    set_per(1, 0, 4'd7, 11'd8);
    nedge(); set_per(0, 0, 0, 0);
    repeat (3) begin
      settle();
      check("R8 valid held", xact_valid_o, 1);
      check("R8 ch held", xact_ch_o, 7);
      check("R8 time held", xact_time_o, 8);
      nedge();
    end
    xact_ready_i = 1'b1;
    nedge(); xact_ready_i = 1'b0; settle();
    check("R8 valid dropped", xact_valid_o, 0);
    nedge(); xact_done_i = 1'b1;
    nedge(); xact_done_i = 1'b0;

    repeat (2) nedge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule